// File: doc/BRIEF.md
# Coin Credit Vending Controller

The block counts coins into a small credit store and unlocks an item once the credit reaches fifteen units. Two single-cycle strobes bring in the coins. One adds five units and the other adds ten. Credit is kept in two flip-flops and stops rising at fifteen. From then on the unlock output stays high until a synchronous reset returns the machine to zero credit.

A parameter selects one of two ways to produce the unlock output:

- **Decoded:** the output is the AND of the two credit flip-flops, placed after the registers.
- **Retimed:** the same AND is moved in front of a third flip-flop and fed from the next-state functions. The output then comes straight from a register, with no gate after the clock.

Both forms give the same waveform. This lets the two be compared directly.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the credit returns to zero and `vendOpen` is low after that edge, in both variants.
- R2: Credit is coded as two bits: 00 means 0 units, 01 means 5, 10 means 10 and 11 means 15 or more. Starting from zero, three five-unit strobes raise `vendOpen` after the edge that takes the third. The first two leave it low.
- R3: A ten-unit strobe followed by a five-unit strobe raises `vendOpen`, and so does a five followed by a ten. In both cases the output is low after the first coin and high after the second.
- R4: Credit saturates at 15. Two ten-unit strobes raise `vendOpen` after the second, with the excess discarded.
- R5: Once `vendOpen` is high, it stays high through any further coin strobes or idle cycles until a reset.
- R6: A cycle with neither strobe leaves the credit, and so `vendOpen`, unchanged.
- R7: A reset in the same cycle as a coin strobe wins. The coin is discarded and the credit restarts from zero.
- R8: With `RETIMED` = 1 the output comes from its own flip-flop, loaded with the AND of both next-state bits. Its waveform is identical, cycle for cycle, to the decoded variant (`RETIMED` = 0) for any legal coin sequence.

The two strobes are never high in the same cycle. This is a contract on the caller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin5 | input | 1 | One-cycle strobe: five units deposited |
| coin10 | input | 1 | One-cycle strobe: ten units deposited |
| vendOpen | output | 1 | High while credit is 15 or more |

## Verification
Two functions can land in the same cycle:

- **Reset with a coin:** the bench drives `rst` together with a coin strobe, both at partial credit and once the output is already high. It then checks that the output is low after that edge, and that the next coins count from zero.
- **Coin at full credit:** a coin can arrive when the credit is already saturated. The bench feeds further five- and ten-unit strobes into an open machine and checks that the output never drops.

A retimed and a decoded instance run side by side on the same random coin stream. Their outputs are compared every cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // Credit coding: 00 = 0, 01 = 5, 10 = 10, 11 = 15 or more
  localparam int CREDIT_W = 2;

  typedef logic [CREDIT_W-1:0] credit_t;

  typedef struct packed {
    logic    clear;      // synchronous reset request
    credit_t nextCredit; // next-state bits {hi, lo}
    logic    openNext;   // unlock value for the retimed output register
  } vend_strobe_t;
endpackage

// File: rtl/vend_next_logic.sv
module vend_next_logic
  import vend_pkg::*;
(
  input  logic         rst,
  input  logic         coin5,
  input  logic         coin10,
  input  credit_t      credit,
  output vend_strobe_t strobe
);
  logic qHi, qLo, nHi, nLo;

  assign qHi = credit[1];
  assign qLo = credit[0];

  // High bit: already 10 or more, a ten-unit coin, or a five on top of five
  assign nHi = qHi | coin10 | (qLo & coin5);

  // Low bit: five from an even credit, hold an odd credit when no five arrives,
  // or any coin on top of ten or more
  assign nLo = (~qLo & coin5) | (qLo & ~coin5) | (qHi & coin5) | (qHi & coin10);

  always_comb begin
    strobe.clear      = rst;
    strobe.nextCredit = {nHi, nLo};
    strobe.openNext   = nHi & nLo;
  end
endmodule

// File: rtl/vend_credit_regs.sv
module vend_credit_regs
  import vend_pkg::*;
#(
  parameter bit RETIMED = 1'b1
) (
  input  logic         clk,
  input  vend_strobe_t strobe,
  output credit_t      credit,
  output logic         vendOpen
);
  always_ff @(posedge clk) begin
    if (strobe.clear) credit <= '0;
    else              credit <= strobe.nextCredit;
  end

  generate
    if (RETIMED) begin : gRetimed
      logic openReg;
      always_ff @(posedge clk) begin
        if (strobe.clear) openReg <= 1'b0;
        else              openReg <= strobe.openNext;
      end
      assign vendOpen = openReg;
    end else begin : gDecoded
      assign vendOpen = &credit;
    end
  endgenerate
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
#(
  parameter bit RETIMED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic coin5,
  input  logic coin10,
  output logic vendOpen
);
  vend_strobe_t strobe;
  credit_t      credit;

  vend_next_logic uNext (
    .rst    (rst),
    .coin5  (coin5),
    .coin10 (coin10),
    .credit (credit),
    .strobe (strobe)
  );

  vend_credit_regs #(.RETIMED(RETIMED)) uRegs (
    .clk      (clk),
    .strobe   (strobe),
    .credit   (credit),
    .vendOpen (vendOpen)
  );
endmodule

// File: rtl/vend_chk.sv
module vend_chk (
  input logic       clk,
  input logic       rst,
  input logic       coin5,
  input logic       coin10,
  input logic [1:0] credit,
  input logic       vendOpen
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !vendOpen && credit == 2'b00);

  // R2
  third_five_chk: assert property (@(posedge clk) disable iff (rst)
    coin5 && credit == 2'b10 |=> vendOpen);

  // R3
  ten_on_credit_chk: assert property (@(posedge clk) disable iff (rst)
    coin10 && credit == 2'b01 |=> vendOpen);

  // R4
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    credit == 2'b11 |=> credit == 2'b11);

  // R5
  hold_open_chk: assert property (@(posedge clk) disable iff (rst)
    vendOpen |=> vendOpen);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !coin5 && !coin10 |=> $stable(credit) && $stable(vendOpen));

  // R8
  open_matches_credit_chk: assert property (@(posedge clk) disable iff (rst)
    vendOpen == (credit == 2'b11));
endmodule

bind coin_vend_ctrl vend_chk uChk (
  .clk      (clk),
  .rst      (rst),
  .coin5    (coin5),
  .coin10   (coin10),
  .credit   (credit),
  .vendOpen (vendOpen)
);

// File: tb/tb_coin_vend_ctrl.sv
`timescale 1ns/1ps
module tb_coin_vend_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin5 = 1'b0;
  logic coin10 = 1'b0;
  logic openRet, openDec;

  always #2.5 clk = ~clk;

  coin_vend_ctrl #(.RETIMED(1'b1)) dut (
    .clk(clk), .rst(rst), .coin5(coin5), .coin10(coin10), .vendOpen(openRet));

  coin_vend_ctrl #(.RETIMED(1'b0)) dutDec (
    .clk(clk), .rst(rst), .coin5(coin5), .coin10(coin10), .vendOpen(openDec));

  typedef struct {
    logic  expOpen;
    string tag;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    errors = 0;
  int    model  = 0; // credit in units of five, capped at 3
  bit    done   = 0;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected output after the next edge
  task automatic step(input bit r, input bit c5, input bit c10, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; coin5 = c5; coin10 = c10;
    if (r) model = 0;
    else if (c5) model = (model + 1 > 3) ? 3 : model + 1;
    else if (c10) model = (model + 2 > 3) ? 3 : model + 2;
    it.expOpen = (model == 3);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(openRet, it.expOpen, {it.tag, " retimed"});
        check(openDec, it.expOpen, {it.tag, " decoded"});
        check(openRet, openDec, "R8 variants equal");
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, "R1 reset");
    step(1, 0, 0, "R1 reset");
    // R2: three fives
    step(0, 1, 0, "R2 five 1");
    step(0, 1, 0, "R2 five 2");
    step(0, 1, 0, "R2 five 3");
    step(1, 0, 0, "R1 reset after open");
    // R6: idle cycles hold credit
    step(0, 1, 0, "R6 five");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R6 idle");
    step(0, 1, 0, "R6 five");
    step(0, 0, 0, "R6 idle");
    step(0, 1, 0, "R6 five opens");
    step(1, 0, 0, "R1 reset");
    // R3: ten then five, five then ten
    step(0, 0, 1, "R3 ten first");
    step(0, 1, 0, "R3 then five");
    step(1, 0, 0, "R1 reset");
    step(0, 1, 0, "R3 five first");
    step(0, 0, 1, "R3 then ten");
    step(1, 0, 0, "R1 reset");
    // R4: two tens saturate
    step(0, 0, 1, "R4 ten 1");
    step(0, 0, 1, "R4 ten 2");
    // R5: coins while open
    step(0, 1, 0, "R5 five on open");
    step(0, 0, 1, "R5 ten on open");
    step(0, 0, 0, "R5 idle on open");
    // R7: reset with coin while open, then at partial credit
    step(1, 0, 1, "R7 reset+ten while open");
    step(0, 0, 1, "R7 ten");
    step(1, 1, 0, "R7 reset+five");
    step(0, 1, 0, "R7 counts from zero");
    step(0, 0, 1, "R7 then ten");
    // R8: random legal stream
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 19);
      if (sel == 0) step(1, 0, 0, "R8 random");
      else if (sel < 8) step(0, 1, 0, "R8 random");
      else if (sel < 12) step(0, 0, 1, "R8 random");
      else step(0, 0, 0, "R8 random");
    end
    step(0, 0, 0, "R6 final idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule